// File: doc/BRIEF.md
# Receive Frame Acceptance Filter With External Reject

This block decides whether each received frame is kept or dropped. It watches the received byte stream and captures the first six bytes as the destination address. While those bytes arrive it also computes a CRC-32 over them to find a hash index. When the last byte of the frame arrives, it combines an exact match against the station address, a broadcast check, a 64-bit multicast hash filter and the mode inputs. An optional external filter can join in through a reject input, and it may supply a tag word that travels with the decision.

Internal hits (physical match, hash hit, broadcast) and promiscuous mode always win over the external reject. The external reject can only drop a frame when the external filter is selected and every internal match source is switched off. In that case external logic alone decides. The reject input is sampled in a window that opens on the cycle after the sixth address byte and closes with the last byte of the frame.

Top module: `rx_accept_filter`

## Requirements
- R1: With `mode_promisc`=1, every frame longer than six bytes is accepted, whatever `ext_sel`, `ext_reject` and the address are.
- R2: A destination equal to `station_addr` is accepted even when the external reject fires, unless `mode_no_phys`=1. The first received byte is compared with `station_addr[7:0]` and the sixth with `station_addr[47:40]`.
- R3: An all-ones destination is accepted even when the external reject fires, unless `mode_no_bcast`=1.
- R4: A group destination (bit 0 of the first byte is 1) other than broadcast is accepted, even with the external reject, when `logical_filter[idx]`=1. Here idx is bits 31:26 of a CRC-32 over the six address bytes, computed with initial value all ones, polynomial 0x04C11DB7, each byte fed LSB first in arrival order, shift-left form and no final inversion.
- R5: With `ext_sel`=0, `ext_reject` has no effect, and a frame is accepted only through R1 to R4.
- R6: The internal filter is off when `mode_promisc`=0, `mode_no_bcast`=1, `mode_no_phys`=1 and `logical_filter`=0. With `ext_sel`=1 in that state, a frame is accepted unless a reject is seen in the window.
- R7: With `ext_sel`=1, the internal filter on and no internal hit, a frame is rejected.
- R8: `ext_reject` counts only from the cycle after the sixth byte up to and including the cycle of the last byte. A reject before or after that window is ignored.
- R9: A frame of six bytes or fewer is rejected in every mode.
- R10: `dec_valid` pulses for one cycle, on the cycle after the byte carrying `rx_eof` is taken.
- R11: `dec_tag` carries the last `ext_tag` given with `ext_tag_valid` inside the window. It is 0 if no tag was given in the window.
- R12: After reset, `dec_valid`, `dec_accept` and `dec_tag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_sof | input | 1 | The byte is the first of a frame |
| rx_eof | input | 1 | The byte is the last of a frame |
| rx_data | input | 8 | Received byte |
| station_addr | input | 48 | Station address, first byte in bits 7:0 |
| logical_filter | input | 64 | Multicast hash filter |
| mode_promisc | input | 1 | Accept all frames |
| mode_no_bcast | input | 1 | Do not accept broadcast by itself |
| mode_no_phys | input | 1 | Do not accept a station address match |
| ext_sel | input | 1 | External filter takes part |
| ext_reject | input | 1 | External filter rejects the current frame |
| ext_tag_valid | input | 1 | `ext_tag` is valid |
| ext_tag | input | 16 | Tag word from the external filter |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | 1 = keep the frame |
| dec_tag | output | 16 | Tag reported with the decision |

## Verification
An error in the captured address or in the CRC state only shows at the decision strobe, one cycle after the last byte of the frame. It then appears as a wrong accept value for a unicast match or a multicast hash hit. For this reason every frame in the bench ends in a compared decision. A sticky reject flag that is stuck, or a window that opens one cycle early or late, shows at the next frame's decision. Frames with the reject placed exactly on the window edges bring such faults out within a single frame.

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int TAG_W      = 16,
  parameter int HASH_BITS  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic                    rx_eof,
  input  logic [7:0]              rx_data,
  input  logic [ADDR_BYTES*8-1:0] station_addr,
  input  logic [63:0]             logical_filter,
  input  logic                    mode_promisc,
  input  logic                    mode_no_bcast,
  input  logic                    mode_no_phys,
  input  logic                    ext_sel,
  input  logic                    ext_reject,
  input  logic                    ext_tag_valid,
  input  logic [TAG_W-1:0]        ext_tag,
  output logic                    dec_valid,
  output logic                    dec_accept,
  output logic [TAG_W-1:0]        dec_tag
);
  localparam int AW = ADDR_BYTES * 8;
  localparam int CW = $clog2(ADDR_BYTES + 1);

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[k]) ? 32'h04C1_1DB7 : 32'h0);
    return r;
  endfunction

  logic             busy, rej_seen;
  logic [CW-1:0]    cnt;
  logic [AW-1:0]    da;
  logic [31:0]      crc;
  logic [TAG_W-1:0] tag_q;

  wire win      = busy && (cnt == CW'(ADDR_BYTES));
  wire is_bcast = &da;
  wire phys_hit = !mode_no_phys && (da == station_addr);
  wire bc_hit   = !mode_no_bcast && is_bcast;
  wire [HASH_BITS-1:0] hash_idx = crc[31 -: HASH_BITS];
  wire laf_hit  = da[0] && !is_bcast && logical_filter[hash_idx];
  wire int_hit  = phys_hit || bc_hit || laf_hit;
  wire int_off  = !mode_promisc && mode_no_bcast && mode_no_phys && (logical_filter == 64'd0);
  wire rej_now  = rej_seen || ext_reject;
  wire accept_now = mode_promisc || int_hit || (ext_sel && int_off && !rej_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; rej_seen <= 1'b0; cnt <= '0; da <= '0; crc <= '1; tag_q <= '0;
      dec_valid <= 1'b0; dec_accept <= 1'b0; dec_tag <= '0;
    end else begin
      dec_valid <= 1'b0;
      if (win && ext_reject) rej_seen <= 1'b1;
      if (win && ext_tag_valid) tag_q <= ext_tag;
      if (rx_valid && rx_sof) begin
        busy     <= !rx_eof;
        cnt      <= CW'(1);
        da       <= {{(AW-8){1'b0}}, rx_data};
        crc      <= crc_byte(32'hFFFF_FFFF, rx_data);
        rej_seen <= 1'b0;
        tag_q    <= '0;
        if (rx_eof) begin
          dec_valid <= 1'b1; dec_accept <= 1'b0; dec_tag <= '0;
        end
      end else if (rx_valid && busy) begin
        if (!win) begin
          da[{cnt, 3'b000} +: 8] <= rx_data;
          crc <= crc_byte(crc, rx_data);
          cnt <= cnt + CW'(1);
        end
        if (rx_eof) begin
          busy       <= 1'b0;
          dec_valid  <= 1'b1;
          dec_accept <= win && accept_now;
          dec_tag    <= (win && ext_tag_valid) ? ext_tag : tag_q;
        end
      end
    end
  end

  AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof && !rx_sof && win && mode_promisc) |=> (dec_valid && dec_accept)); // R1
  AST_NOEXT_OFF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof && !ext_sel && !mode_promisc && mode_no_bcast && mode_no_phys
     && logical_filter == 64'd0) |=> (dec_valid && !dec_accept)); // R5
  AST_EXT_ONLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof && !rx_sof && win && ext_sel && int_off && !rej_seen && !ext_reject)
    |=> dec_accept); // R6
  AST_RUNT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_eof && (rx_sof || !win)) |=> (dec_valid && !dec_accept)); // R9
  AST_DEC_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(rx_valid && rx_eof)); // R10
  AST_REJ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!win && !(rx_valid && rx_sof)) |=> $stable(rej_seen) || !busy); // R8
endmodule

// File: tb/test_rx_accept_filter.sv
module test_rx_accept_filter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 0;
  logic [47:0] station_addr = 48'hA5_4B_3C_2D_1E_02;
  logic [63:0] logical_filter = 0;
  logic mode_promisc = 0, mode_no_bcast = 0, mode_no_phys = 0, ext_sel = 0;
  logic ext_reject = 0, ext_tag_valid = 0;
  logic [15:0] ext_tag = 0;
  logic dec_valid, dec_accept;
  logic [15:0] dec_tag;
  int checks = 0, errors = 0;
  logic exp_acc_q[$];
  logic [15:0] exp_tag_q[$];
  string exp_req_q[$];

  always #5 clk = ~clk;

  rx_accept_filter i_rx_accept_filter (.*);

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ d[k]) ? 32'h04C1_1DB7 : 32'h0);
    return r;
  endfunction

  function automatic int hash_of(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) c = crc_step(c, a[8*i +: 8]);
    return int'(c[31:26]);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dec_valid) begin
      if (exp_acc_q.size() == 0) chk("R10 unexpected decision", 1, 0);
      else begin
        string r;
        r = exp_req_q.pop_front();
        chk({r, " accept"}, 32'(dec_accept), 32'(exp_acc_q.pop_front()));
        chk({r, " tag"}, 32'(dec_tag), 32'(exp_tag_q.pop_front()));
      end
    end
  end

  task automatic send(input logic [47:0] da, input int len, input int rej_at,
                      input int tag_at, input logic [15:0] tag,
                      input logic exp_acc, input logic [15:0] exp_tag, input string req);
    exp_acc_q.push_back(exp_acc);
    exp_tag_q.push_back(exp_tag);
    exp_req_q.push_back(req);
    for (int i = 0; i <= len; i++) begin
      @(negedge clk);
      if (i == len) chk({"R10 strobe ", req}, 32'(dec_valid), 1);
      rx_valid = (i < len);
      rx_sof = (i == 0);
      rx_eof = (i == len - 1);
      rx_data = (i < 6) ? da[8*i +: 8] : 8'(i);
      ext_reject = (i == rej_at);
      ext_tag_valid = (i == tag_at);
      ext_tag = tag;
    end
    @(negedge clk);
    chk({"R10 single pulse ", req}, 32'(dec_valid), 0);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; ext_reject = 0; ext_tag_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    logic [47:0] mc, other;
    int idx;
    mc = 48'h00_00_00_5E_00_01;
    other = 48'h10_20_30_40_50_60;
    idx = hash_of(mc);
    repeat (3) @(negedge clk);
    chk("R12 dec_valid", 32'(dec_valid), 0);
    chk("R12 dec_accept", 32'(dec_accept), 0);
    chk("R12 dec_tag", 32'(dec_tag), 0);
    rst_n = 1;
    @(negedge clk);

    send(station_addr, 12, -1, 7, 16'h1234, 1, 16'h1234, "R2 match no ext, R11 tag");
    send(other, 12, 8, -1, 0, 0, 0, "R5 no ext unmatched with reject");
    send(station_addr, 12, 8, -1, 0, 1, 0, "R5 no ext match with reject");
    ext_sel = 1;
    send(station_addr, 12, 8, -1, 0, 1, 0, "R2 match overrides reject");
    send(48'hFFFF_FFFF_FFFF, 10, 7, -1, 0, 1, 0, "R3 broadcast overrides reject");
    send(other, 10, -1, -1, 0, 0, 0, "R7 enabled, no hit, no reject");
    mode_no_bcast = 1;
    send(48'hFFFF_FFFF_FFFF, 10, -1, -1, 0, 0, 0, "R3 broadcast disabled");
    mode_no_bcast = 0;
    logical_filter = 64'd1 << idx;
    send(mc, 10, 8, -1, 0, 1, 0, "R4 hash hit overrides reject");
    logical_filter = 64'd1 << (idx ^ 1);
    send(mc, 10, -1, -1, 0, 0, 0, "R4 hash miss");
    logical_filter = 0;
    mode_promisc = 1;
    send(other, 10, 7, -1, 0, 1, 0, "R1 promisc ext with reject");
    ext_sel = 0;
    send(other, 10, -1, -1, 0, 1, 0, "R1 promisc no ext");
    send(station_addr, 6, -1, -1, 0, 0, 0, "R9 six-byte frame");
    mode_promisc = 0;
    send(station_addr, 4, -1, -1, 0, 0, 0, "R9 four-byte frame");
    ext_sel = 1; mode_no_bcast = 1; mode_no_phys = 1;
    send(other, 10, -1, 8, 16'hBEEF, 1, 16'hBEEF, "R6 external only, no reject");
    send(other, 10, 7, -1, 0, 0, 0, "R6 external only, reject");
    send(other, 10, 5, -1, 0, 1, 0, "R8 reject before window");
    send(other, 10, 10, -1, 0, 1, 0, "R8 reject after eof");
    send(other, 10, 9, -1, 0, 0, 0, "R8 reject on last byte");
    send(other, 10, 6, 3, 16'h7777, 0, 0, "R8 reject first window cycle, R11 early tag");
    send(station_addr, 10, 7, -1, 0, 0, 0, "R2 phys disabled");
    repeat (3) @(negedge clk);
    chk("R10 all decisions seen", 32'(exp_acc_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule